// File: doc/BRIEF.md
# Four-Channel Prescaled PWM Controller

This block generates four independent pulse-width-modulated outputs from a single input clock. Each channel owns a 6-bit clock prescaler, a 16-bit period count, a 16-bit high-time count, a polarity bit, an enable bit and a drive-type bit. Software programs these through a simple 32-bit register bus made of an address, a write strobe, write data and combinational read data. Every register is a full word, so software updates the shared control word and the packed prescale word with read-modify-write.

A running channel produces a waveform whose period is (prescale+1)·period input-clock cycles. It is in its active state for the first (prescale+1)·duty cycles of each period. New prescale, period and duty values written while a channel runs are taken at the next period boundary, which keeps the output free of glitches. A channel whose enable bit is cleared is locked out of re-enabling for a programmable hold-off time.

Top module: `pwm4_ctrl`

## Requirements
- R1: After reset every register reads as zero. Because polarity 0 means inverted, all four outputs then sit at their inactive level of 1.
- R2: The control word at offset 0x00 holds enable for channel n at bit n, polarity at bit 8+n and drive type at bit 15+n, and reads back as written. The drive-type bit has no effect on the output waveform.
- R3: The period count for channel n is at offset 0x04+8n and the duty count at offset 0x08+8n. Writes keep bits 15:0, and bits 31:16 read as zero.
- R4: The prescale word at offset 0x24 holds channel n in bits (3−n)·6+5 down to (3−n)·6, so channel 3 is in bits 5:0 and channel 0 is in bits 23:18. Bits 31:24 read as zero, and every other offset (above 0x24 or not word-aligned) reads as zero.
- R5: An enabled channel has a period of (prescale+1)·period clock cycles and is active for the first (prescale+1)·duty of them. The first active cycle is the clock cycle after the one in which the enable bit becomes set.
- R6: Polarity 1 drives the output high while active and low while inactive. Polarity 0 inverts both levels.
- R7: A duty count greater than or equal to the period count holds the output constantly active. A duty count of 0 holds it constantly inactive.
- R8: A period count of 0 or 1 behaves as a period count of 2.
- R9: Prescale, period and duty written while a channel runs take effect only at the start of its next period. The current period finishes with the old values.
- R10: Within one cycle after its enable bit clears, a channel drives its inactive level and its counters restart from zero.
- R11: For HOLDOFF_CYCLES cycles after a channel's enable bit is cleared, a control write that sets that bit leaves it at 0. The write still updates the other fields of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for the registers and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe; the write takes effect at the next rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 4 | PWM outputs, bit n is channel n |

## Verification
The bound checker watches, on every cycle, the following: inactive levels of disabled channels, the one-cycle lock that holds an enable bit at 0 right after it clears, the active first cycle after an enable with non-zero duty, the landing of polarity bits from control writes, and zero read data at unused offsets. Several behaviours need the bench's scenarios instead, because they span many cycles or depend on a programmed history. These are the exact waveform shape against the prescale and period arithmetic, the reversed packing of prescale fields, the saturated and zero duty cases, period clamping, and the deferred update at a period boundary. The full hold-off window is also checked only by the bench.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int NCH        = 4;
    localparam int ADDR_W     = 8;
    localparam int CTRL_OFS   = 'h00;
    localparam int PER_BASE   = 'h04;
    localparam int DUTY_BASE  = 'h08;
    localparam int CH_STRIDE  = 8;
    localparam int PRESC_OFS  = 'h24;
    localparam int POL_LSB    = 8;
    localparam int DRV_LSB    = 15;
    localparam int MIN_PERIOD = 2;
endpackage

// File: rtl/pwm4_regs.sv
module pwm4_regs
    import pwm4_pkg::*;
#(
    parameter int PRE_W          = 6,
    parameter int CNT_W          = 16,
    parameter int HOLDOFF_CYCLES = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [NCH-1:0]          en_o,
    output logic [NCH-1:0]          pol_o,
    output logic [NCH*PRE_W-1:0]    pre_o,
    output logic [NCH*CNT_W-1:0]    per_o,
    output logic [NCH*CNT_W-1:0]    duty_o
);
    localparam int HW = $clog2(HOLDOFF_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LD = HW'(HOLDOFF_CYCLES);

    typedef struct packed {
        logic [NCH-1:0]             en;
        logic [NCH-1:0]             pol;
        logic [NCH-1:0]             drv;
        logic [NCH-1:0][PRE_W-1:0]  pre;
        logic [NCH-1:0][CNT_W-1:0]  per;
        logic [NCH-1:0][CNT_W-1:0]  duty;
        logic [NCH-1:0][HW-1:0]     hold;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            if (st_q.hold[n] != '0) st_d.hold[n] = st_q.hold[n] - HW'(1);
        end
        if (we) begin
            if (addr == ADDR_W'(CTRL_OFS)) begin
                for (int n = 0; n < NCH; n++) begin
                    st_d.pol[n] = wdata[POL_LSB + n];
                    st_d.drv[n] = wdata[DRV_LSB + n];
                    // a set request is honoured only when already on or lock expired
                    st_d.en[n]  = wdata[n] && (st_q.en[n] || st_q.hold[n] == '0);
                    if (st_q.en[n] && !wdata[n]) st_d.hold[n] = HOLD_LD;
                end
            end else if (addr == ADDR_W'(PRESC_OFS)) begin
                for (int n = 0; n < NCH; n++) begin
                    st_d.pre[n] = wdata[(NCH-1-n)*PRE_W +: PRE_W];
                end
            end else begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr == ADDR_W'(PER_BASE + CH_STRIDE*n))  st_d.per[n]  = wdata[CNT_W-1:0];
                    if (addr == ADDR_W'(DUTY_BASE + CH_STRIDE*n)) st_d.duty[n] = wdata[CNT_W-1:0];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTRL_OFS)) begin
            for (int n = 0; n < NCH; n++) begin
                rdata[n]           = st_q.en[n];
                rdata[POL_LSB + n] = st_q.pol[n];
                rdata[DRV_LSB + n] = st_q.drv[n];
            end
        end else if (addr == ADDR_W'(PRESC_OFS)) begin
            for (int n = 0; n < NCH; n++) begin
                rdata[(NCH-1-n)*PRE_W +: PRE_W] = st_q.pre[n];
            end
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (addr == ADDR_W'(PER_BASE + CH_STRIDE*n))  rdata[CNT_W-1:0] = st_q.per[n];
                if (addr == ADDR_W'(DUTY_BASE + CH_STRIDE*n)) rdata[CNT_W-1:0] = st_q.duty[n];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign pol_o  = st_q.pol;
    assign pre_o  = st_q.pre;
    assign per_o  = st_q.per;
    assign duty_o = st_q.duty;
endmodule

// File: rtl/pwm4_chan.sv
module pwm4_chan
    import pwm4_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [PRE_W-1:0] pre,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm
);
    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre_cnt;
        logic [CNT_W-1:0] per_cnt;
        logic [PRE_W-1:0] pre_s;
        logic [CNT_W-1:0] per_s;
        logic [CNT_W-1:0] duty_s;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic [CNT_W-1:0] per_eff;
    logic             active;

    assign per_eff = (per < CNT_W'(MIN_PERIOD)) ? CNT_W'(MIN_PERIOD) : per;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.run     = 1'b0;
            st_d.pre_cnt = '0;
            st_d.per_cnt = '0;
        end else if (!st_q.run) begin
            st_d.run     = 1'b1;
            st_d.pre_cnt = '0;
            st_d.per_cnt = '0;
            st_d.pre_s   = pre;
            st_d.per_s   = per_eff;
            st_d.duty_s  = duty;
        end else if (st_q.pre_cnt == st_q.pre_s) begin
            st_d.pre_cnt = '0;
            if (st_q.per_cnt == st_q.per_s - CNT_W'(1)) begin
                st_d.per_cnt = '0;
                st_d.pre_s   = pre;
                st_d.per_s   = per_eff;
                st_d.duty_s  = duty;
            end else begin
                st_d.per_cnt = st_q.per_cnt + CNT_W'(1);
            end
        end else begin
            st_d.pre_cnt = st_q.pre_cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.run && (st_q.per_cnt < st_q.duty_s);
    assign pwm    = pol ? active : !active;
endmodule

// File: rtl/pwm4_ctrl.sv
module pwm4_ctrl
    import pwm4_pkg::*;
#(
    parameter int PRE_W          = 6,
    parameter int CNT_W          = 16,
    parameter int HOLDOFF_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_out
);
    logic [NCH-1:0]       ch_en;
    logic [NCH-1:0]       ch_pol;
    logic [NCH*PRE_W-1:0] pre_flat;
    logic [NCH*CNT_W-1:0] per_flat;
    logic [NCH*CNT_W-1:0] duty_flat;

    pwm4_regs #(
        .PRE_W(PRE_W), .CNT_W(CNT_W), .HOLDOFF_CYCLES(HOLDOFF_CYCLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata), .en_o(ch_en), .pol_o(ch_pol),
        .pre_o(pre_flat), .per_o(per_flat), .duty_o(duty_flat)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm4_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .en(ch_en[g]), .pol(ch_pol[g]),
            .pre(pre_flat[g*PRE_W +: PRE_W]),
            .per(per_flat[g*CNT_W +: CNT_W]),
            .duty(duty_flat[g*CNT_W +: CNT_W]),
            .pwm(pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm4_ctrl_chk.sv
module pwm4_ctrl_chk
    import pwm4_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [7:0]           bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NCH-1:0]       ch_en,
    input logic [NCH-1:0]       ch_pol,
    input logic [NCH*CNT_W-1:0] duty_flat,
    input logic [3:0]           pwm_out
);
    // R4
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > 8'(PRESC_OFS) || bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0);

    // R2
    pol_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'(CTRL_OFS)) |=> ch_pol == $past(bus_wdata[POL_LSB +: NCH]));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R10
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_en[g] && !$past(ch_en[g])) |-> pwm_out[g] == !ch_pol[g]);

        // R11
        holdoff_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_en[g]) |=> !ch_en[g]);

        // R5
        start_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ch_en[g]) && duty_flat[g*CNT_W +: CNT_W] != '0) |=> pwm_out[g] == ch_pol[g]);
    end
endmodule

bind pwm4_ctrl pwm4_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_en(ch_en),
    .ch_pol(ch_pol), .duty_flat(duty_flat), .pwm_out(pwm_out)
);

// File: tb/test_pwm4_ctrl.sv
module test_pwm4_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        int    ch;
        logic  exp;
        string req;
    } sb_item_t;
    sb_item_t sbq[$];

    pwm4_ctrl i_pwm4_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: compare queued expectations at their cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at < cyc) begin
                check({sbq[i].req, " stale"}, 32'(pwm_out[sbq[i].ch]), 32'(sbq[i].exp));
                sbq.delete(i);
            end else if (sbq[i].at == cyc) begin
                check(sbq[i].req, 32'(pwm_out[sbq[i].ch]), 32'(sbq[i].exp));
                sbq.delete(i);
            end
        end
    end

    task automatic push_wave(input int ch, input int start, input int n, input int pre,
                             input int pc, input int dc, input logic pol, input string req);
        for (int t = 0; t < n; t++) begin
            sb_item_t it;
            logic act;
            act = ((t / (pre + 1)) % pc) < dc;
            it.at = start + t; it.ch = ch; it.exp = pol ? act : !act; it.req = req;
            sbq.push_back(it);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int c);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; c = cyc;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(posedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c;
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); check("R1 ctrl", v, 32'h0);
        rd(8'h04, v); check("R1 period0", v, 32'h0);
        rd(8'h24, v); check("R1 prescale", v, 32'h0);
        @(negedge clk); check("R1 outputs", 32'(pwm_out), 32'hF);

        // R3 period/duty map
        wr(8'h14, 32'hABCD_1234, c); rd(8'h14, v); check("R3 period2", v, 32'h0000_1234);
        wr(8'h10, 32'hFFFF_00FF, c); rd(8'h10, v); check("R3 duty1", v, 32'h0000_00FF);
        wr(8'h20, 32'h0001_8000, c); rd(8'h20, v); check("R3 duty3", v, 32'h0000_8000);

        // R4 prescale packing and unused offsets
        wr(8'h24, 32'hFFFF_FFFF, c); rd(8'h24, v); check("R4 prescale width", v, 32'h00FF_FFFF);
        rd(8'h28, v); check("R4 unused 0x28", v, 32'h0);
        rd(8'h06, v); check("R4 unaligned", v, 32'h0);

        // R5 + R2: channel 0, prescale 1 in bits 23:18, type bit set
        wr(8'h24, 32'(1) << 18, c);
        wr(8'h04, 32'd5, c);
        wr(8'h08, 32'd2, c);
        wr(8'h00, 32'h0000_8101, c);
        push_wave(0, c + 2, 30, 1, 5, 2, 1'b1, "R5 ch0 wave (R2 type ignored)");
        drain();
        rd(8'h00, v); check("R2 ctrl readback", v, 32'h0000_8101);
        wr(8'h00, 32'h0000_0100, c); idle(3);
        @(negedge clk); check("R10 ch0 idle level", 32'(pwm_out[0]), 32'h0);
        idle(50);

        // R4 + R5: channel 3, prescale 2 in bits 5:0
        wr(8'h24, 32'd2, c);
        wr(8'h1C, 32'd3, c);
        wr(8'h20, 32'd1, c);
        wr(8'h00, 32'h0000_0808, c);
        push_wave(3, c + 2, 27, 2, 3, 1, 1'b1, "R4 ch3 prescale field");
        drain();
        wr(8'h00, 32'h0000_0800, c); idle(50);

        // R6: channel 1 inverted
        wr(8'h24, 32'd0, c);
        wr(8'h0C, 32'd4, c);
        wr(8'h10, 32'd1, c);
        wr(8'h00, 32'h0000_0002, c);
        push_wave(1, c + 2, 16, 0, 4, 1, 1'b0, "R6 ch1 inverted");
        drain();
        wr(8'h00, 32'h0000_0000, c); idle(3);
        @(negedge clk); check("R10 ch1 idle level inverted", 32'(pwm_out[1]), 32'h1);
        idle(50);

        // R7: duty >= period, then duty 0
        wr(8'h14, 32'd3, c);
        wr(8'h18, 32'd7, c);
        wr(8'h00, 32'h0000_0404, c);
        push_wave(2, c + 2, 12, 0, 3, 7, 1'b1, "R7 duty saturated");
        drain();
        wr(8'h00, 32'h0000_0400, c); idle(50);
        wr(8'h18, 32'd0, c);
        wr(8'h00, 32'h0000_0404, c);
        push_wave(2, c + 2, 12, 0, 3, 0, 1'b1, "R7 duty zero");
        drain();
        wr(8'h00, 32'h0000_0400, c); idle(50);

        // R8: period 1 behaves as 2
        wr(8'h04, 32'd1, c);
        wr(8'h08, 32'd1, c);
        wr(8'h00, 32'h0000_0101, c);
        push_wave(0, c + 2, 12, 0, 2, 1, 1'b1, "R8 period clamp");
        drain();
        wr(8'h00, 32'h0000_0100, c); idle(50);

        // R9: period change lands at boundary
        wr(8'h04, 32'd4, c);
        wr(8'h08, 32'd2, c);
        wr(8'h00, 32'h0000_0101, c);
        push_wave(0, c + 2, 4, 0, 4, 2, 1'b1, "R9 old period");
        begin
            int s;
            s = c + 2;
            wr(8'h04, 32'd6, c);
            push_wave(0, s + 4, 18, 0, 6, 2, 1'b1, "R9 new period");
        end
        drain();

        // R11: hold-off after disable
        wr(8'h00, 32'h0000_0100, c);
        wr(8'h00, 32'h0000_0101, c);
        rd(8'h00, v); check("R11 re-enable blocked", v, 32'h0000_0100);
        @(negedge clk); check("R11 output stays inactive", 32'(pwm_out[0]), 32'h0);
        wr(8'h00, 32'h0000_0001, c);
        rd(8'h00, v); check("R11 other fields written", v, 32'h0000_0000);
        @(negedge clk); check("R11 inverted inactive", 32'(pwm_out[0]), 32'h1);
        idle(45);
        wr(8'h00, 32'h0000_0101, c);
        rd(8'h00, v); check("R11 re-enable after hold-off", v, 32'h0000_0101);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule